// File: doc/BRIEF.md
# BCD Time-of-Day and Calendar Counter Chain

This block keeps wall-clock time and a calendar in packed BCD. A clock enable at 32.768 kHz steps a binary prescaler. Each time the prescaler wraps, it produces a one-second step. That step ripples through the seconds, minutes, hours, weekday, day-of-month, month and year fields in the same clock cycle. Hours run in either a 24-hour or a 12-hour format, and each stored hour value selects its own format. The day-of-month limit comes from a month-length table. February has 29 days when the two-digit year is a multiple of four.

A byte-wide write port loads any field, or a small control byte, at one of eight addresses. A write to the seconds field also restarts the prescaler. The field then holds the new value for one full second, and the 1 Hz square wave restarts its phase from that write. The control byte starts and stops the oscillator path. An oscillator-stop flag records that the time may be invalid. Reset sets the flag, stopping the oscillator sets it again, and software clears it.

Top module: `rtc_bcd_chain`

## Requirements
- R1: After reset the outputs read: seconds 00h, minutes 00h, hours 00h (24-hour), weekday 01h, date 01h, month 01h, year 00h, square wave low, oscillator running 1, stop flag 1.
- R2: While running, seconds advance by one BCD count every 2^PRE_W tick enables. Seconds and minutes wrap from 59h to 00h, and each wrap advances the next field in the same cycle.
- R3: A write to address 0 loads the seconds value and clears the prescaler in the same cycle, and drives the square wave low at once. The value holds for exactly 2^PRE_W enables, then advances by one.
- R4: After a prescaler restart the square wave rises after 2^(PRE_W-1) enables. It falls after 2^PRE_W enables, in the same cycle that seconds advance.
- R5: In 24-hour format (hours bit 6 = 0, bits 5:0 BCD 00–23), hours go 23h to 00h and advance the day. A BCD carry such as 09h to 10h is handled.
- R6: In 12-hour format (bit 6 = 1, bit 5 = PM, bits 4:0 BCD 01–12), 11 toggles to 12 with AM/PM inverted, and 12 goes to 01. Only 11 PM to 12 AM advances the day. For example 51h to 72h, 71h to 52h, 72h to 61h.
- R7: The weekday field (address 3) counts 1 to 7 and wraps to 1. It advances on the same day step as the date.
- R8: The date (address 4) wraps to 01h after 31h, 30h (months 04h, 06h, 09h, 11h) or 28h/29h (month 02h, 29h when year mod 4 = 0), and advances the month. The month (address 5) wraps 12h to 01h and advances the year. The year (address 6) wraps 99h to 00h.
- R9: When control bit 7 is 0, the prescaler, the square wave and all fields hold their values.
- R10: A write to address 7 sets the running state from bit 7. Writing bit 7 = 0 sets the stop flag. Writing bit 7 = 1 with bit 5 = 0 clears it. Writing bit 7 = 1 with bit 5 = 1 leaves it unchanged.
- R11: A write to a field at address 1–6 loads that field in the same cycle. It takes precedence over that field's increment, and that field then passes no carry onward in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| tick_en | input | 1 | One-cycle enable at the 32.768 kHz oscillator rate |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | 0 sec, 1 min, 2 hour, 3 weekday, 4 date, 5 month, 6 year, 7 control |
| wr_data | input | 8 | Write data |
| sec_o | output | 8 | Seconds, BCD |
| min_o | output | 8 | Minutes, BCD |
| hour_o | output | 8 | Hours with format and AM/PM bits |
| dow_o | output | 8 | Weekday 1–7 |
| date_o | output | 8 | Day of month, BCD |
| month_o | output | 8 | Month, BCD |
| year_o | output | 8 | Two-digit year, BCD |
| sqw_o | output | 1 | 1 Hz square wave |
| osc_run_o | output | 1 | Oscillator path running |
| stop_flag_o | output | 1 | Oscillator-stop flag |

## Verification
A wrong prescaler value shows only on the square wave and on the seconds field, up to one full second later. The square-wave edges and the seconds increment are therefore timed in enables from each seconds write, not merely sampled. A wrong carry or roof value stays hidden until a field reaches its limit. The bench loads each limit directly and steps across it in one second: hour formats, month lengths, leap years and the year wrap. Any wrong state then appears on the next second's edge.

// File: rtl/rtc_chain_pkg.sv
package rtc_chain_pkg;

  localparam int NUM_FIELDS = 7;

  localparam int F_SEC   = 0;
  localparam int F_MIN   = 1;
  localparam int F_HOUR  = 2;
  localparam int F_DOW   = 3;
  localparam int F_DATE  = 4;
  localparam int F_MONTH = 5;
  localparam int F_YEAR  = 6;

  localparam logic [2:0] ADDR_CTRL = 3'd7;
  localparam int CTRL_RUN_BIT  = 7;
  localparam int CTRL_KEEP_BIT = 5;

  function automatic logic [7:0] bcd_next(input logic [7:0] v);
    if (v[3:0] >= 4'd9) return {v[7:4] + 4'd1, 4'd0};
    else                return {v[7:4], v[3:0] + 4'd1};
  endfunction

  function automatic logic [7:0] field_floor(input int k);
    case (k)
      F_DOW, F_DATE, F_MONTH: return 8'h01;
      default:                return 8'h00;
    endcase
  endfunction

  function automatic logic [7:0] field_roof(input int k);
    case (k)
      F_SEC, F_MIN: return 8'h59;
      F_DOW:        return 8'h07;
      F_MONTH:      return 8'h12;
      default:      return 8'h99;
    endcase
  endfunction

  function automatic logic [7:0] last_day(input logic [7:0] month, input logic [7:0] year);
    logic [6:0] ybin;
    ybin = 7'(year[7:4]) * 7'd10 + 7'(year[3:0]);
    case (month)
      8'h02:                      return (ybin[1:0] == 2'b00) ? 8'h29 : 8'h28;
      8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
      default:                    return 8'h31;
    endcase
  endfunction

endpackage

// File: rtl/rtc_prescaler.sv
module rtc_prescaler #(
  parameter int unsigned CNT_W = 15
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic tick_en,
  input  logic restart,
  output logic half_o,
  output logic wrap_o
);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic             adv;

  assign adv    = run & tick_en;
  assign wrap_o = adv & ~restart & (&cnt_q);
  assign half_o = cnt_q[CNT_W-1];

  always_comb begin
    cnt_d = cnt_q;
    if (restart)  cnt_d = '0;
    else if (adv) cnt_d = cnt_q + {{(CNT_W-1){1'b0}}, 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

endmodule

// File: rtl/rtc_bcd_field.sv
module rtc_bcd_field #(
  parameter logic [7:0] FLOOR = 8'h00
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       step,
  input  logic [7:0] roof,
  input  logic       load,
  input  logic [7:0] load_val,
  output logic [7:0] val_o,
  output logic       carry_o
);
  import rtc_chain_pkg::*;

  logic [7:0] val_q;
  logic [7:0] val_d;
  logic       at_roof;

  assign at_roof = (val_q == roof);
  assign carry_o = step & ~load & at_roof;
  assign val_o   = val_q;

  always_comb begin
    val_d = val_q;
    if (load)      val_d = load_val;
    else if (step) val_d = at_roof ? FLOOR : bcd_next(val_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) val_q <= FLOOR;
    else        val_q <= val_d;
  end

endmodule

// File: rtl/rtc_hour_field.sv
module rtc_hour_field (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       step,
  input  logic       load,
  input  logic [7:0] load_val,
  output logic [7:0] val_o,
  output logic       carry_o
);
  import rtc_chain_pkg::*;

  logic [7:0] val_q;
  logic [7:0] val_d;
  logic [7:0] inc12;
  logic [7:0] inc24;
  logic       twelve;
  logic       day_wrap;

  assign twelve   = val_q[6];
  assign inc12    = bcd_next({3'b000, val_q[4:0]});
  assign inc24    = bcd_next({2'b00, val_q[5:0]});
  assign day_wrap = twelve ? ((val_q[4:0] == 5'h11) & val_q[5]) : (val_q[5:0] == 6'h23);
  assign carry_o  = step & ~load & day_wrap;
  assign val_o    = val_q;

  always_comb begin
    val_d = val_q;
    if (load) begin
      val_d = load_val;
    end else if (step) begin
      if (twelve) begin
        if (val_q[4:0] == 5'h12)      val_d = {val_q[7:5], 5'h01};
        else if (val_q[4:0] == 5'h11) val_d = {val_q[7:6], ~val_q[5], 5'h12};
        else                          val_d = {val_q[7:5], inc12[4:0]};
      end else begin
        if (val_q[5:0] == 6'h23) val_d = {val_q[7:6], 6'h00};
        else                     val_d = {val_q[7:6], inc24[5:0]};
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) val_q <= 8'h00;
    else        val_q <= val_d;
  end

endmodule

// File: rtl/rtc_bcd_chain.sv
module rtc_bcd_chain #(
  parameter int unsigned PRE_W = 15
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick_en,
  input  logic       wr_en,
  input  logic [2:0] wr_addr,
  input  logic [7:0] wr_data,
  output logic [7:0] sec_o,
  output logic [7:0] min_o,
  output logic [7:0] hour_o,
  output logic [7:0] dow_o,
  output logic [7:0] date_o,
  output logic [7:0] month_o,
  output logic [7:0] year_o,
  output logic       sqw_o,
  output logic       osc_run_o,
  output logic       stop_flag_o
);
  import rtc_chain_pkg::*;

  localparam int unsigned SYNC_STAGES = 2;

  // reset: asynchronous assert, synchronous release
  logic [SYNC_STAGES-1:0] rst_pipe_q;
  logic                   rst_core_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= '0;
    else        rst_pipe_q <= {rst_pipe_q[SYNC_STAGES-2:0], 1'b1};
  end
  assign rst_core_n = rst_pipe_q[SYNC_STAGES-1];

  // write decode
  logic [NUM_FIELDS-1:0] wr_hit;
  logic                  wr_ctrl;

  assign wr_ctrl = wr_en & (wr_addr == ADDR_CTRL);

  // control state
  logic run_q, run_d;
  logic stop_q, stop_d;

  always_comb begin
    run_d  = run_q;
    stop_d = stop_q;
    if (wr_ctrl) begin
      run_d = wr_data[CTRL_RUN_BIT];
      if (!wr_data[CTRL_RUN_BIT])      stop_d = 1'b1;
      else if (!wr_data[CTRL_KEEP_BIT]) stop_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) begin
      run_q  <= 1'b1;
      stop_q <= 1'b1;
    end else begin
      run_q  <= run_d;
      stop_q <= stop_d;
    end
  end

  // prescaler
  logic sec_tick;
  logic half_sec;

  rtc_prescaler #(.CNT_W(PRE_W)) u_pre (
    .clk     (clk),
    .rst_n   (rst_core_n),
    .run     (run_q),
    .tick_en (tick_en),
    .restart (wr_hit[F_SEC]),
    .half_o  (half_sec),
    .wrap_o  (sec_tick)
  );

  // counter chain
  logic [7:0]            fld_q [NUM_FIELDS];
  logic [NUM_FIELDS-1:0] step;
  logic [NUM_FIELDS-1:0] carry;

  for (genvar k = 0; k < NUM_FIELDS; k++) begin : g_field
    assign wr_hit[k] = wr_en & (wr_addr == 3'(k));

    if (k == F_SEC) begin : g_step_tick
      assign step[k] = sec_tick;
    end else if (k == F_DATE) begin : g_step_day
      assign step[k] = carry[F_HOUR];
    end else begin : g_step_ripple
      assign step[k] = carry[k-1];
    end

    if (k == F_HOUR) begin : g_hour
      rtc_hour_field u_hour (
        .clk      (clk),
        .rst_n    (rst_core_n),
        .step     (step[k]),
        .load     (wr_hit[k]),
        .load_val (wr_data),
        .val_o    (fld_q[k]),
        .carry_o  (carry[k])
      );
    end else begin : g_plain
      logic [7:0] roof;
      if (k == F_DATE) begin : g_roof_month
        assign roof = last_day(fld_q[F_MONTH], fld_q[F_YEAR]);
      end else begin : g_roof_fixed
        assign roof = field_roof(k);
      end
      rtc_bcd_field #(.FLOOR(field_floor(k))) u_fld (
        .clk      (clk),
        .rst_n    (rst_core_n),
        .step     (step[k]),
        .roof     (roof),
        .load     (wr_hit[k]),
        .load_val (wr_data),
        .val_o    (fld_q[k]),
        .carry_o  (carry[k])
      );
    end
  end

  logic unused_carry_tail;
  assign unused_carry_tail = carry[F_DOW] & carry[F_YEAR];

  assign sec_o       = fld_q[F_SEC];
  assign min_o       = fld_q[F_MIN];
  assign hour_o      = fld_q[F_HOUR];
  assign dow_o       = fld_q[F_DOW];
  assign date_o      = fld_q[F_DATE];
  assign month_o     = fld_q[F_MONTH];
  assign year_o      = fld_q[F_YEAR];
  assign sqw_o       = half_sec;
  assign osc_run_o   = run_q;
  assign stop_flag_o = stop_q;

endmodule

// File: rtl/rtc_chain_chk.sv
module rtc_chain_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       wr_en,
  input logic [2:0] wr_addr,
  input logic [7:0] wr_data,
  input logic [7:0] sec_o,
  input logic [7:0] min_o,
  input logic [7:0] dow_o,
  input logic [7:0] date_o,
  input logic       sqw_o,
  input logic       osc_run_o,
  input logic       stop_flag_o
);

  AST_SEC_WRITE_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == 3'd0) |=> (sec_o == $past(wr_data) && !sqw_o)); // R3

  AST_SEC_STEP_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(wr_en) && !$stable(sec_o)) |-> $fell(sqw_o)); // R4

  AST_MIN_AFTER_SEC_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(wr_en) && !$stable(min_o)) |-> ($past(sec_o) == 8'h59 && sec_o == 8'h00)); // R2

  AST_DOW_WITH_DATE: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(wr_en) && !$stable(dow_o)) |-> !$stable(date_o)); // R7

  AST_HALT_FREEZES: assert property (@(posedge clk) disable iff (!rst_n)
    (!osc_run_o && !wr_en) |=> ($stable(sec_o) && $stable(sqw_o))); // R9

  AST_HALT_SETS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == 3'd7 && !wr_data[7]) |=> (stop_flag_o && !osc_run_o)); // R10

endmodule

bind rtc_bcd_chain rtc_chain_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_core_n),
  .wr_en       (wr_en),
  .wr_addr     (wr_addr),
  .wr_data     (wr_data),
  .sec_o       (sec_o),
  .min_o       (min_o),
  .dow_o       (dow_o),
  .date_o      (date_o),
  .sqw_o       (sqw_o),
  .osc_run_o   (osc_run_o),
  .stop_flag_o (stop_flag_o)
);

// File: tb/sim_rtc_bcd_chain.sv
`timescale 1ns/1ps
module sim_rtc_bcd_chain;

  localparam int unsigned PW = 4;
  localparam int PERIOD = 1 << PW;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick = 1'b0;
  logic       we = 1'b0;
  logic [2:0] wa = 3'd0;
  logic [7:0] wd = 8'd0;
  logic [7:0] sec, mins, hour, dow, date, month, year;
  logic       sqw, run, flag;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  rtc_bcd_chain #(.PRE_W(PW)) u0 (
    .clk(clk), .rst_n(rst_n), .tick_en(tick), .wr_en(we), .wr_addr(wa), .wr_data(wd),
    .sec_o(sec), .min_o(mins), .hour_o(hour), .dow_o(dow), .date_o(date),
    .month_o(month), .year_o(year), .sqw_o(sqw), .osc_run_o(run), .stop_flag_o(flag)
  );

  // reference model state
  int         m_pre;
  logic [7:0] m_f [7];
  bit         m_run, m_flag;

  function automatic int b2i(input logic [7:0] b);
    return int'(b[7:4]) * 10 + int'(b[3:0]);
  endfunction

  function automatic logic [7:0] i2b(input int v);
    return {4'(v / 10), 4'(v % 10)};
  endfunction

  function automatic int mdays(input int mo, input int yr);
    if (mo == 2) return (yr % 4 == 0) ? 29 : 28;
    if (mo == 4 || mo == 6 || mo == 9 || mo == 11) return 30;
    return 31;
  endfunction

  task automatic model_step(input bit t, input bit w, input logic [2:0] a, input logic [7:0] d);
    logic [7:0] nf [7];
    bit c, dayc, pm, pmn;
    int v, hr;
    nf = m_f;
    c = m_run && t && (m_pre == PERIOD - 1) && !(w && a == 3'd0);
    if (w && a == 3'd0) m_pre = 0;
    else if (m_run && t) m_pre = (m_pre + 1) % PERIOD;
    // seconds, minutes
    for (int k = 0; k < 2; k++) begin
      if (c) begin
        v = b2i(m_f[k]);
        if (v == 59) begin nf[k] = 8'h00; c = 1; end
        else begin nf[k] = i2b(v + 1); c = 0; end
      end
      if (w && a == 3'(k)) begin nf[k] = d; c = 0; end
    end
    // hours
    dayc = 0;
    if (c) begin
      if (!m_f[2][6]) begin
        v = b2i({2'b00, m_f[2][5:0]});
        if (v == 23) begin nf[2] = 8'h00; dayc = 1; end
        else nf[2] = i2b(v + 1);
      end else begin
        v = b2i({3'b000, m_f[2][4:0]});
        pm = m_f[2][5];
        pmn = pm;
        if (v == 11) begin hr = 12; pmn = !pm; dayc = pm; end
        else if (v == 12) hr = 1;
        else hr = v + 1;
        nf[2] = 8'h40 | (pmn ? 8'h20 : 8'h00) | i2b(hr);
      end
    end
    if (w && a == 3'd2) begin nf[2] = d; dayc = 0; end
    // weekday
    if (dayc) nf[3] = (b2i(m_f[3]) == 7) ? 8'h01 : i2b(b2i(m_f[3]) + 1);
    if (w && a == 3'd3) nf[3] = d;
    // date
    c = 0;
    if (dayc) begin
      v = b2i(m_f[4]);
      if (v == mdays(b2i(m_f[5]), b2i(m_f[6]))) begin nf[4] = 8'h01; c = 1; end
      else nf[4] = i2b(v + 1);
    end
    if (w && a == 3'd4) begin nf[4] = d; c = 0; end
    // month
    if (c) begin
      v = b2i(m_f[5]);
      if (v == 12) begin nf[5] = 8'h01; c = 1; end
      else begin nf[5] = i2b(v + 1); c = 0; end
    end
    if (w && a == 3'd5) begin nf[5] = d; c = 0; end
    // year
    if (c) nf[6] = (b2i(m_f[6]) == 99) ? 8'h00 : i2b(b2i(m_f[6]) + 1);
    if (w && a == 3'd6) nf[6] = d;
    // control
    if (w && a == 3'd7) begin
      m_run = d[7];
      if (!d[7]) m_flag = 1;
      else if (!d[5]) m_flag = 0;
    end
    m_f = nf;
  endtask

  task automatic cyc(input bit t, input bit w, input logic [2:0] a, input logic [7:0] d);
    tick = t; we = w; wa = a; wd = d;
    model_step(t, w, a, d);
    @(negedge clk);
    tick = 0; we = 0;
  endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic cmp(input string tag);
    logic [58:0] a, e;
    a = {sec, mins, hour, dow, date, month, year, sqw, run, flag};
    e = {m_f[0], m_f[1], m_f[2], m_f[3], m_f[4], m_f[5], m_f[6],
         (m_pre >= PERIOD / 2) ? 1'b1 : 1'b0, m_run, m_flag};
    n_chk++;
    if (a !== e) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, a, e);
    end
  endtask

  task automatic set_time(input logic [7:0] s, input logic [7:0] mi, input logic [7:0] h,
                          input logic [7:0] dw, input logic [7:0] dt, input logic [7:0] mo,
                          input logic [7:0] yr);
    cyc(0, 1, 3'd6, yr); cyc(0, 1, 3'd5, mo); cyc(0, 1, 3'd4, dt); cyc(0, 1, 3'd3, dw);
    cyc(0, 1, 3'd2, h);  cyc(0, 1, 3'd1, mi); cyc(0, 1, 3'd0, s);
  endtask

  task automatic one_second();
    repeat (PERIOD) cyc(1, 0, 3'd0, 8'h00);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  function automatic logic [7:0] rand_val(input logic [2:0] a);
    case (a)
      3'd0: return ($urandom % 3 == 0) ? 8'h59 : i2b($urandom % 60);
      3'd1: return ($urandom % 3 == 0) ? 8'h59 : i2b($urandom % 60);
      3'd2: return ($urandom % 2 == 0) ? i2b($urandom % 24)
                   : (8'h40 | (($urandom % 2 == 0) ? 8'h20 : 8'h00) | i2b(1 + $urandom % 12));
      3'd3: return i2b(1 + $urandom % 7);
      3'd4: return i2b(1 + $urandom % 28);
      3'd5: return i2b(1 + $urandom % 12);
      3'd6: return i2b($urandom % 100);
      default: return ($urandom % 4 == 0) ? 8'h00 : (($urandom % 2 == 0) ? 8'h80 : 8'hA0);
    endcase
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog R1: actual hung expected finished");
    finish_run();
  end

  initial begin
    logic [7:0] held_sec;
    logic       held_sqw;
    void'($urandom(32'h0000_5EED));
    m_pre = 0; m_run = 1; m_flag = 1;
    m_f[0] = 8'h00; m_f[1] = 8'h00; m_f[2] = 8'h00; m_f[3] = 8'h01;
    m_f[4] = 8'h01; m_f[5] = 8'h01; m_f[6] = 8'h00;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (3) @(negedge clk);

    // R1 reset state
    cmp("R1 reset");
    chk("R1 stop flag", {31'd0, flag}, 32'd1);
    chk("R1 weekday", {24'd0, dow}, 32'h01);

    // R10 flag control
    cyc(0, 1, 3'd7, 8'hA0);
    chk("R10 keep bit leaves flag", {31'd0, flag}, 32'd1);
    cyc(0, 1, 3'd7, 8'h80);
    chk("R10 clear flag", {31'd0, flag}, 32'd0);

    // R3 / R4 seconds write restarts the divider
    repeat (5) cyc(1, 0, 3'd0, 8'h00);
    cyc(1, 1, 3'd0, 8'h03);
    chk("R3 seconds loaded", {24'd0, sec}, 32'h03);
    chk("R3 square wave low", {31'd0, sqw}, 32'd0);
    repeat (PERIOD / 2 - 1) cyc(1, 0, 3'd0, 8'h00);
    chk("R4 low before half", {31'd0, sqw}, 32'd0);
    cyc(1, 0, 3'd0, 8'h00);
    chk("R4 high at half", {31'd0, sqw}, 32'd1);
    repeat (PERIOD / 2 - 1) cyc(1, 0, 3'd0, 8'h00);
    chk("R3 value held full second", {24'd0, sec}, 32'h03);
    cyc(1, 0, 3'd0, 8'h00);
    chk("R3 advance after one second", {24'd0, sec}, 32'h04);
    chk("R4 low at one second", {31'd0, sqw}, 32'd0);
    repeat (PERIOD / 2 + 2) cyc(1, 0, 3'd0, 8'h00);
    chk("R4 high mid second", {31'd0, sqw}, 32'd1);
    cyc(1, 1, 3'd0, 8'h30);
    chk("R3 write pulls wave low", {31'd0, sqw}, 32'd0);
    chk("R3 seconds reloaded", {24'd0, sec}, 32'h30);
    cmp("R3 full state");

    // R2 R5 R7 R8 day / month rollover, non-leap February
    set_time(8'h59, 8'h59, 8'h23, 8'h07, 8'h28, 8'h02, 8'h23);
    one_second();
    chk("R2 minutes wrap", {24'd0, mins}, 32'h00);
    chk("R5 hour wrap", {24'd0, hour}, 32'h00);
    chk("R7 weekday wrap", {24'd0, dow}, 32'h01);
    chk("R8 feb 28 wraps", {16'd0, month, date}, 32'h0301);
    cmp("R8 state");

    // R8 leap February
    set_time(8'h59, 8'h59, 8'h23, 8'h03, 8'h28, 8'h02, 8'h24);
    one_second();
    chk("R8 leap feb 29", {16'd0, month, date}, 32'h0229);

    // R8 year wrap
    set_time(8'h59, 8'h59, 8'h23, 8'h05, 8'h31, 8'h12, 8'h99);
    one_second();
    chk("R8 year wrap", {8'd0, year, month, date}, 32'h000101);

    // R8 thirty-day month
    set_time(8'h59, 8'h59, 8'h23, 8'h02, 8'h30, 8'h04, 8'h10);
    one_second();
    chk("R8 april 30", {16'd0, month, date}, 32'h0501);
    chk("R7 weekday step", {24'd0, dow}, 32'h03);

    // R5 BCD carry in 24-hour mode
    set_time(8'h59, 8'h59, 8'h09, 8'h02, 8'h10, 8'h04, 8'h10);
    one_second();
    chk("R5 09 to 10", {24'd0, hour}, 32'h10);

    // R6 12-hour mode
    set_time(8'h59, 8'h59, 8'h51, 8'h02, 8'h10, 8'h04, 8'h10);
    one_second();
    chk("R6 11AM to 12PM", {16'd0, hour, date}, 32'h7210);
    set_time(8'h59, 8'h59, 8'h72, 8'h02, 8'h10, 8'h04, 8'h10);
    one_second();
    chk("R6 12PM to 1PM", {24'd0, hour}, 32'h61);
    set_time(8'h59, 8'h59, 8'h71, 8'h02, 8'h15, 8'h04, 8'h10);
    one_second();
    chk("R6 11PM to 12AM day step", {16'd0, hour, date}, 32'h5216);
    set_time(8'h59, 8'h59, 8'h45, 8'h02, 8'h15, 8'h04, 8'h10);
    one_second();
    chk("R6 5AM to 6AM", {24'd0, hour}, 32'h46);

    // R11 write wins over carry
    set_time(8'h59, 8'h59, 8'h05, 8'h02, 8'h15, 8'h04, 8'h10);
    repeat (PERIOD - 1) cyc(1, 0, 3'd0, 8'h00);
    cyc(1, 1, 3'd1, 8'h42);
    chk("R11 minutes written on wrap", {16'd0, sec, mins}, 32'h0042);
    chk("R11 no hour carry", {24'd0, hour}, 32'h05);
    cyc(0, 1, 3'd6, 8'h77);
    chk("R11 year load", {24'd0, year}, 32'h77);

    // R9 R10 halt
    cyc(0, 1, 3'd7, 8'h00);
    chk("R10 halt sets flag", {30'd0, run, flag}, 32'b01);
    held_sec = sec;
    held_sqw = sqw;
    repeat (3 * PERIOD) cyc(1, 0, 3'd0, 8'h00);
    chk("R9 seconds held", {24'd0, sec}, {24'd0, held_sec});
    chk("R9 wave held", {31'd0, sqw}, {31'd0, held_sqw});
    cmp("R9 full state held");
    cyc(0, 1, 3'd7, 8'h80);
    chk("R10 restart clears flag", {30'd0, run, flag}, 32'b10);

    // constrained random phase
    for (int i = 0; i < 4000; i++) begin
      bit t, w;
      logic [2:0] a;
      t = ($urandom % 4) != 0;
      w = ($urandom % 30) == 0;
      a = 3'($urandom % 8);
      cyc(t, w, a, rand_val(a));
      cmp("R2 R11 random");
    end

    finish_run();
  end

endmodule